// File: doc/BRIEF.md
# Nibble-to-Byte Handshake Bridge

This block joins a producer that emits 4-bit values to a consumer that takes 8-bit values. The producer places each nibble on `nib_data` and raises `nib_strobe` for one or more clock cycles. The bridge takes two such nibbles, treats the first as the low half and the second as the high half, and hands the assembled byte to the consumer on `byte_data` together with a one-cycle pulse on `byte_strobe`.

Internally a controller walks through a fixed ring of eight states. For each nibble it waits for the strobe, grabs the data on the following cycle, then waits for the strobe to drop. After both halves it loads the output register in one state and lets the output pulse end in the next. Because the controller follows both the rising and the falling phase of every strobe, a strobe held high for many cycles still counts as a single nibble. All state is clocked on one edge with a synchronous active-low reset. The receiver cannot apply back-pressure.

Top module: `nib2byte_bridge`

## Requirements
- R1: While `rst_n` is low at a clock edge, `byte_data` becomes 0 and `byte_strobe` becomes 0, and the bridge then expects a low nibble.
- R2: Each byte produced equals {second nibble, first nibble}: the first nibble of a pair fills bits 3:0 and the second fills bits 7:4.
- R3: A nibble is sampled from `nib_data` at the clock edge right after the first edge at which `nib_strobe` is seen high. Later changes to `nib_data` while the strobe stays high have no effect on the byte.
- R4: After taking a nibble the bridge waits until `nib_strobe` is seen low, so a strobe held high over any number of cycles is taken as one nibble.
- R5: `byte_strobe` is high for exactly one clock cycle per pair of nibbles, and never in two consecutive cycles.
- R6: If the second nibble's strobe is first seen high at edge e and stays high for L edges, `byte_strobe` and the new `byte_data` appear after edge e + max(2, L) + 1.
- R7: `byte_data` keeps the last assembled byte until the next byte is produced, and changes only in the cycle in which `byte_strobe` is high.
- R8: A reset in the middle of a pair discards the captured low nibble, so the next strobe after reset is taken as a new low nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| nib_strobe | input | 1 | Marks a nibble on `nib_data`; may be held high for several cycles |
| nib_data | input | NIB_W (4) | Incoming nibble, stable from strobe rise until one edge after |
| byte_strobe | output | 1 | One-cycle pulse marking a new byte |
| byte_data | output | 2*NIB_W (8) | Last assembled byte, high nibble above low nibble |

## Verification
The controller needs one edge to see a strobe and one more to sample the data. It leaves the drain state no earlier than two edges after the strobe was seen, and its output register adds one further edge. So the byte pulse for a second nibble whose strobe is first seen at edge e and held L edges lands after edge e + max(2, L) + 1. The bench counts rising edges, notes the edge at which it raised each strobe, and records the edge index of every output pulse at the falling edge that follows. It compares that index to the formula. It also compares the number of pulses and the byte value, and does so only once enough idle cycles have passed for the pulse to be over.

// File: rtl/nbb_pkg.sv
// Shared types for the nibble-to-byte bridge.
// Assumes: one controller state per step of the two-nibble handshake.
package nbb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE_LO  = 3'd0,
        ST_GRAB_LO  = 3'd1,
        ST_DRAIN_LO = 3'd2,
        ST_IDLE_HI  = 3'd3,
        ST_GRAB_HI  = 3'd4,
        ST_DRAIN_HI = 3'd5,
        ST_EMIT     = 3'd6,
        ST_EMIT_END = 3'd7
    } nbb_state_e;

endpackage

// File: rtl/nbb_ctrl.sv
// Handshake controller: follows each strobe through its rise and fall,
// issues one load per nibble slot and one load for the output word.
// Assumes: nib_strobe is synchronous to clk; reset is synchronous, active low.
module nbb_ctrl
    import nbb_pkg::*;
#(
    parameter int SLOTS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nib_strobe,
    output logic [SLOTS-1:0] slot_ld,
    output logic             emit_ld
);

    nbb_state_e state_q;
    nbb_state_e state_d;

    // Purpose: hold the current handshake step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE_LO;
        end else begin
            state_q <= state_d;
        end
    end

    // Purpose: choose the next step from the current one and the strobe.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE_LO:  if (nib_strobe)  state_d = ST_GRAB_LO;
            ST_GRAB_LO:                   state_d = ST_DRAIN_LO;
            ST_DRAIN_LO: if (!nib_strobe) state_d = ST_IDLE_HI;
            ST_IDLE_HI:  if (nib_strobe)  state_d = ST_GRAB_HI;
            ST_GRAB_HI:                   state_d = ST_DRAIN_HI;
            ST_DRAIN_HI: if (!nib_strobe) state_d = ST_EMIT;
            ST_EMIT:                      state_d = ST_EMIT_END;
            ST_EMIT_END:                  state_d = ST_IDLE_LO;
            default:                      state_d = ST_IDLE_LO;
        endcase
    end

    // Purpose: decode the datapath load strobes from the current step.
    always_comb begin
        slot_ld    = '0;
        slot_ld[0] = (state_q == ST_GRAB_LO);
        slot_ld[1] = (state_q == ST_GRAB_HI);
        emit_ld    = (state_q == ST_EMIT);
    end

endmodule

// File: rtl/nbb_nibble_store.sv
// Holding registers, one per nibble slot; slot 0 is the low half.
// Assumes: at most one slot load is active per cycle.
module nbb_nibble_store #(
    parameter int NIB_W = 4,
    parameter int SLOTS = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NIB_W-1:0]       nib_in,
    input  logic [SLOTS-1:0]       slot_ld,
    output logic [SLOTS*NIB_W-1:0] word_o
);

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [NIB_W-1:0] slot_q;

        // Purpose: capture the incoming nibble when this slot is selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (slot_ld[g]) begin
                slot_q <= nib_in;
            end
        end

        assign word_o[g*NIB_W +: NIB_W] = slot_q;
    end

endmodule

// File: rtl/nbb_out_reg.sv
// Output register: holds the assembled word and produces the one-cycle
// strobe that accompanies a new word.
// Assumes: emit_ld is high for a single cycle per word.
module nbb_out_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         emit_ld,
    input  logic [W-1:0] word_i,
    output logic [W-1:0] byte_o,
    output logic         strobe_o
);

    // Purpose: load the word and raise the strobe for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_o   <= '0;
            strobe_o <= 1'b0;
        end else begin
            strobe_o <= emit_ld;
            if (emit_ld) begin
                byte_o <= word_i;
            end
        end
    end

endmodule

// File: rtl/nib2byte_bridge.sv
// Top of the nibble-to-byte bridge: controller, nibble store, output register.
// Assumes: the producer keeps nib_data stable from strobe rise to one edge later.
module nib2byte_bridge #(
    parameter int NIB_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 nib_strobe,
    input  logic [NIB_W-1:0]     nib_data,
    output logic                 byte_strobe,
    output logic [2*NIB_W-1:0]   byte_data
);

    localparam int SLOTS  = 2;
    localparam int BYTE_W = SLOTS * NIB_W;

    logic [SLOTS-1:0]  slot_ld;
    logic              emit_ld;
    logic [BYTE_W-1:0] word;

    nbb_ctrl #(
        .SLOTS (SLOTS)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .nib_strobe (nib_strobe),
        .slot_ld    (slot_ld),
        .emit_ld    (emit_ld)
    );

    nbb_nibble_store #(
        .NIB_W (NIB_W),
        .SLOTS (SLOTS)
    ) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .nib_in  (nib_data),
        .slot_ld (slot_ld),
        .word_o  (word)
    );

    nbb_out_reg #(
        .W (BYTE_W)
    ) out_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .emit_ld  (emit_ld),
        .word_i   (word),
        .byte_o   (byte_data),
        .strobe_o (byte_strobe)
    );

endmodule

// File: rtl/nbb_checker.sv
// Protocol checks for the bridge, attached to the top by bind.
// Assumes: sampled on the rising clock edge.
module nbb_checker #(
    parameter int NIB_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               nib_strobe,
    input logic               lo_ld,
    input logic               byte_strobe,
    input logic [2*NIB_W-1:0] byte_data
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (byte_strobe == 1'b0 && byte_data == '0)); // R1

    AST_LO_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        lo_ld |-> $past(nib_strobe)); // R3

    AST_EMIT_AFTER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        byte_strobe |-> !$past(nib_strobe, 2)); // R4

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_strobe |=> !byte_strobe); // R5

    AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_strobe |=> (byte_strobe || $stable(byte_data))); // R7

endmodule

bind nib2byte_bridge nbb_checker #(
    .NIB_W (NIB_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .nib_strobe  (nib_strobe),
    .lo_ld       (slot_ld[0]),
    .byte_strobe (byte_strobe),
    .byte_data   (byte_data)
);

// File: tb/nib2byte_bridge_tb_top.sv
// Self-checking bench for the nibble-to-byte bridge.
module nib2byte_bridge_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nib_strobe = 1'b0;
    logic [3:0] nib_data = 4'h0;
    logic       byte_strobe;
    logic [7:0] byte_data;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int pulses = 0;
    int doubles = 0;
    int last_cyc = 0;
    logic [7:0] last_byte = 8'h00;
    logic prev_strobe = 1'b0;
    bit finished = 1'b0;

    // fields: lo, hi, first length, second length, gap
    localparam logic [19:0] VEC [8] = '{
        {4'h3, 4'h5, 4'd1,  4'd1,  4'd2},
        {4'hA, 4'hC, 4'd2,  4'd3,  4'd2},
        {4'hF, 4'h0, 4'd1,  4'd5,  4'd3},
        {4'h0, 4'hF, 4'd4,  4'd1,  4'd2},
        {4'h7, 4'h8, 4'd9,  4'd2,  4'd4},
        {4'h1, 4'hE, 4'd3,  4'd15, 4'd2},
        {4'h6, 4'h6, 4'd1,  4'd2,  4'd7},
        {4'h9, 4'h4, 4'd12, 4'd12, 4'd2}
    };

    nib2byte_bridge dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .nib_strobe  (nib_strobe),
        .nib_data    (nib_data),
        .byte_strobe (byte_strobe),
        .byte_data   (byte_data)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: record every output pulse at the falling edge
    always @(negedge clk) begin
        if (rst_n && byte_strobe) begin
            pulses    <= pulses + 1;
            last_byte <= byte_data;
            last_cyc  <= cyc;
            if (prev_strobe) doubles <= doubles + 1;
        end
        prev_strobe <= byte_strobe;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // drive one nibble; returns the edge index at which the strobe is first seen
    task automatic send_nib(input logic [3:0] d, input int len, input int gap, output int e);
        @(negedge clk);
        nib_data   = d;
        nib_strobe = 1'b1;
        e = cyc + 1;
        repeat (len) @(negedge clk);
        nib_strobe = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic run_pair(input logic [3:0] lo, input logic [3:0] hi,
                            input int l1, input int l2, input int gap);
        int p0, ea, eh, due;
        p0 = pulses;
        send_nib(lo, l1, gap, ea);
        send_nib(hi, l2, 0, eh);
        repeat (6) @(negedge clk);
        #1;
        due = eh + ((l2 > 2) ? l2 : 2) + 1;
        chk(pulses == p0 + 1, "R5 one pulse per pair", pulses - p0, 1);
        chk(last_byte == {hi, lo}, "R2 byte assembly", last_byte, {hi, lo});
        chk(last_cyc == due, "R6 pulse timing", last_cyc, due);
        chk(doubles == 0, "R5 pulse width", doubles, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", cyc, 0);
        finish_run();
    end

    initial begin
        int e0, e1;
        logic [7:0] held;
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk(byte_data == 8'h00, "R1 reset data", byte_data, 0);
        chk(byte_strobe == 1'b0, "R1 reset strobe", byte_strobe, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(pulses == 0, "R1 idle after reset", pulses, 0);

        // table walk: R2 R5 R6, long strobes cover R4
        for (int i = 0; i < 8; i++) begin
            run_pair(VEC[i][19:16], VEC[i][15:12], int'(VEC[i][11:8]),
                     int'(VEC[i][7:4]), int'(VEC[i][3:0]));
        end

        // R4: a 15-cycle strobe is one nibble; no pulse after the low one alone
        begin
            int p0;
            p0 = pulses;
            send_nib(4'h2, 15, 6, e0);
            #1;
            chk(pulses == p0, "R4 held strobe counts once", pulses - p0, 0);
            send_nib(4'hB, 1, 6, e1);
            #1;
            chk(pulses == p0 + 1 && last_byte == 8'hB2, "R4 pair after long strobe", last_byte, 8'hB2);
        end

        // R7: output holds between pairs
        held = byte_data;
        repeat (12) @(negedge clk);
        #1;
        chk(byte_data == held, "R7 hold", byte_data, held);

        // R3: data changes after capture edge are ignored
        @(negedge clk);
        nib_data = 4'h5; nib_strobe = 1'b1;
        @(negedge clk); @(negedge clk);
        nib_data = 4'hE;
        repeat (3) @(negedge clk);
        nib_strobe = 1'b0;
        repeat (3) @(negedge clk);
        @(negedge clk);
        nib_data = 4'hC; nib_strobe = 1'b1;
        @(negedge clk); @(negedge clk);
        nib_data = 4'h1;
        repeat (2) @(negedge clk);
        nib_strobe = 1'b0;
        repeat (6) @(negedge clk);
        #1;
        chk(last_byte == 8'hC5, "R3 late data ignored", last_byte, 8'hC5);
        chk(byte_data == 8'hC5, "R7 data matches pulse", byte_data, 8'hC5);

        // R8: reset mid-pair drops the low nibble
        send_nib(4'hA, 2, 3, e0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        chk(byte_data == 8'h00 && byte_strobe == 1'b0, "R1 reset mid-pair", byte_data, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_pair(4'h3, 4'h5, 1, 1, 2);
        chk(last_byte == 8'h53, "R8 fresh pair after reset", last_byte, 8'h53);

        finish_run();
    end

endmodule